// File: doc/BRIEF.md
# Multicycle Instruction Sequencer with Compact Datapath

This block runs a small load/store instruction set one instruction at a time. Each instruction passes through a finite-state sequencer. Every instruction starts with a fetch state and a decode state. After decode, the instruction's class decides how many further states it needs. A conditional branch or a jump is done after three cycles. A store is done after four. Register arithmetic, immediate arithmetic and loads are done after five. An opcode the block does not recognise is dropped after two cycles. The datapath is built from a few registers: an instruction register, two operand latches, an execution-result register and a write-back register. One register file holds 32 words, and entry zero is wired to read zero.

Instruction memory and data memory are separate, and both sit outside the block on plain, single-cycle ports. The instruction word at `imem_addr` must be valid in the same cycle. The read data at `dmem_addr` must also be valid in the same cycle. There is no handshake and no back-pressure: memory wait states are not supported, so every access completes in the cycle the state machine issues it.

For measuring cycles per instruction, the block drives three outputs:
- a one-cycle retire pulse,
- a free-running cycle counter,
- a retired-instruction counter.

Top module: `mc_core`

## Requirements
- R1: While `rst_n` is low, `pc` equals `RESET_PC` (default 0), both counters read 0, and `retire` and `dmem_we` are low. Reset is asynchronous.
- R2: The first state of every instruction is a fetch. In that cycle `imem_addr` equals `pc`, the word is latched, and `pc` advances by 4 at the clock edge. `pc` then holds until the last state of the instruction.
- R3: Register arithmetic (opcode bits [31:26] = 0x00) writes rs op rt into rd. Field positions are rs [25:21], rt [20:16], rd [15:11], shamt [10:6] and funct [5:0]. The operations are funct 0x20 add, 0x22 subtract, 0x24 and, 0x25 or, and 0x2A signed set-less-than. The instruction takes 5 cycles.
- R4: Immediate arithmetic writes rt and takes 5 cycles. Opcode 0x08 adds the sign-extended imm [15:0]. Opcode 0x0C ands with the zero-extended imm, and opcode 0x0D ors with the zero-extended imm.
- R5: A load (opcode 0x23) reads data memory at rs + sign-extended imm and writes the word to rt. It takes 5 cycles.
- R6: A store (opcode 0x2B) takes 4 cycles. It asserts `dmem_we` for exactly one cycle, the last one. In that cycle `dmem_addr` is rs + sign-extended imm and `dmem_wdata` is rt.
- R7: Opcode 0x04 branches when rs equals rt, and opcode 0x05 branches when they differ. Both take 3 cycles. When the branch is taken, the next `pc` is (address + 4) + (sign-extended imm shifted left by 2); otherwise it is address + 4.
- R8: A jump (opcode 0x02) takes 3 cycles. The next `pc` is {bits [31:28] of address + 4, target [25:0], 2'b00}.
- R9: Register 0 always reads as zero, and writes to it are discarded.
- R10: Any other opcode retires after 2 cycles. It changes no register and no memory, and the next `pc` is address + 4.
- R11: `retire` is high for exactly one cycle, the final state of each instruction. `retire_count` increments once per retire pulse.
- R12: `cycle_count` increments on every clock edge outside reset. After a program runs, it equals the sum of the per-instruction cycle counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| imem_addr | output | 32 | Instruction fetch address |
| imem_rdata | input | 32 | Instruction word at `imem_addr`, same cycle |
| dmem_addr | output | 32 | Data memory byte address |
| dmem_wdata | output | 32 | Store data |
| dmem_we | output | 1 | Store strobe, one cycle per store |
| dmem_rdata | input | 32 | Load data at `dmem_addr`, same cycle |
| pc | output | 32 | Current program counter |
| retire | output | 1 | High in the final cycle of each instruction |
| cycle_count | output | CNT_W | Clock edges since reset |
| retire_count | output | CNT_W | Instructions retired since reset |

## Verification
An instruction's address is due on `pc` in its fetch cycle, which is the first cycle after the previous retire edge. Its retire pulse is due 2, 3, 4 or 5 cycles later, counting the fetch cycle as cycle 1, depending on its class. A store's write appears only in that final cycle. The bench samples at the falling edge, counts cycles from the fetch sample until `retire` is seen, and compares the count and any store strobe against a per-instruction trace table. Register results are exposed by later stores, and the counters are read one falling edge after the last retire, when they must equal the summed cycles and the instruction count.

// File: rtl/mc_pkg.sv
package mc_pkg;

  localparam int XLEN = 32;

  localparam logic [5:0] OP_RR   = 6'h00;
  localparam logic [5:0] OP_JMP  = 6'h02;
  localparam logic [5:0] OP_BEQ  = 6'h04;
  localparam logic [5:0] OP_BNE  = 6'h05;
  localparam logic [5:0] OP_ADDI = 6'h08;
  localparam logic [5:0] OP_ANDI = 6'h0C;
  localparam logic [5:0] OP_ORI  = 6'h0D;
  localparam logic [5:0] OP_LOAD = 6'h23;
  localparam logic [5:0] OP_STOR = 6'h2B;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef enum logic [3:0] {
    S_FETCH, S_DECODE, S_EXEC_RR, S_EXEC_RI, S_ADDR,
    S_BRANCH, S_JUMP, S_MEM_RD, S_MEM_WR, S_ALU_WB, S_WRITE
  } state_e;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_SLT, ALU_ZERO
  } alu_op_e;

endpackage

// File: rtl/mc_alu.sv
module mc_alu
  import mc_pkg::*;
#(
  parameter int W = XLEN
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_op_e      op,
  output logic [W-1:0] y
);

  always_comb begin
    unique case (op)
      ALU_ADD: y = a + b;
      ALU_SUB: y = a - b;
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_SLT: y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
      default: y = '0;
    endcase
  end

endmodule

// File: rtl/mc_regfile.sv
module mc_regfile #(
  parameter int W    = 32,
  parameter int NREG = 32,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic [AW-1:0] ra_a,
  input  logic [AW-1:0] ra_b,
  output logic [W-1:0]  rd_a,
  output logic [W-1:0]  rd_b,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd
);

  logic [W-1:0] regs [NREG];

  // entry 0 is never written; reads of it are forced to zero
  always_ff @(posedge clk) begin
    if (we && (wa != '0)) regs[wa] <= wd;
  end

  assign rd_a = (ra_a == '0) ? '0 : regs[ra_a];
  assign rd_b = (ra_b == '0) ? '0 : regs[ra_b];

endmodule

// File: rtl/mc_sequencer.sv
module mc_sequencer
  import mc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [5:0] opcode,
  output state_e     state,
  output logic       retire
);

  state_e nxt;
  logic   known_op;

  always_comb begin
    unique case (opcode)
      OP_RR, OP_JMP, OP_BEQ, OP_BNE, OP_ADDI,
      OP_ANDI, OP_ORI, OP_LOAD, OP_STOR: known_op = 1'b1;
      default:                           known_op = 1'b0;
    endcase
  end

  always_comb begin
    nxt = state;
    unique case (state)
      S_FETCH:  nxt = S_DECODE;
      S_DECODE: begin
        unique case (opcode)
          OP_RR:                 nxt = S_EXEC_RR;
          OP_ADDI, OP_ANDI,
          OP_ORI:                nxt = S_EXEC_RI;
          OP_LOAD, OP_STOR:      nxt = S_ADDR;
          OP_BEQ, OP_BNE:        nxt = S_BRANCH;
          OP_JMP:                nxt = S_JUMP;
          default:               nxt = S_FETCH;
        endcase
      end
      S_EXEC_RR, S_EXEC_RI: nxt = S_ALU_WB;
      S_ALU_WB:             nxt = S_WRITE;
      S_ADDR:   nxt = (opcode == OP_LOAD) ? S_MEM_RD : S_MEM_WR;
      S_MEM_RD:             nxt = S_WRITE;
      default:              nxt = S_FETCH;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= S_FETCH;
    else        state <= nxt;
  end

  assign retire = (state == S_WRITE) || (state == S_MEM_WR) ||
                  (state == S_BRANCH) || (state == S_JUMP) ||
                  ((state == S_DECODE) && !known_op);

  p_fetch_to_decode_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_FETCH) |=> (state == S_DECODE));

  p_retire_to_fetch_r11: assert property (@(posedge clk) disable iff (!rst_n)
    retire |=> (state == S_FETCH));

endmodule

// File: rtl/mc_core.sv
module mc_core
  import mc_pkg::*;
#(
  parameter logic [31:0] RESET_PC = 32'h0,
  parameter int          CNT_W    = 32,
  parameter int          NREG     = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [31:0]      imem_addr,
  input  logic [31:0]      imem_rdata,
  output logic [31:0]      dmem_addr,
  output logic [31:0]      dmem_wdata,
  output logic             dmem_we,
  input  logic [31:0]      dmem_rdata,
  output logic [31:0]      pc,
  output logic             retire,
  output logic [CNT_W-1:0] cycle_count,
  output logic [CNT_W-1:0] retire_count
);

  localparam int RA_W = $clog2(NREG);

  state_e      state;
  logic        retire_w;
  logic [31:0] pc_q, ir_q, a_q, b_q, r_q, wb_q;
  logic [CNT_W-1:0] cyc_q, ret_q;

  logic [5:0]  opcode, funct;
  logic [4:0]  f_rs, f_rt, f_rd;
  logic [31:0] imm_sext, imm_zext, imm_ext, alu_b, alu_y, rf_a, rf_b;
  alu_op_e     alu_op;
  logic        br_taken, rf_we;
  logic [4:0]  rf_wsel;

  assign opcode   = ir_q[31:26];
  assign f_rs     = ir_q[25:21];
  assign f_rt     = ir_q[20:16];
  assign f_rd     = ir_q[15:11];
  assign funct    = ir_q[5:0];
  assign imm_sext = {{16{ir_q[15]}}, ir_q[15:0]};
  assign imm_zext = {16'h0000, ir_q[15:0]};
  assign imm_ext  = ((opcode == OP_ANDI) || (opcode == OP_ORI)) ? imm_zext : imm_sext;

  mc_sequencer u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .opcode (opcode),
    .state  (state),
    .retire (retire_w)
  );

  mc_regfile #(.W(XLEN), .NREG(NREG)) u_rf (
    .clk  (clk),
    .ra_a (f_rs[RA_W-1:0]),
    .ra_b (f_rt[RA_W-1:0]),
    .rd_a (rf_a),
    .rd_b (rf_b),
    .we   (rf_we),
    .wa   (rf_wsel[RA_W-1:0]),
    .wd   (wb_q)
  );

  always_comb begin
    alu_op = ALU_ADD;
    if (state == S_EXEC_RR) begin
      if (ir_q[10:6] != 5'd0) alu_op = ALU_ZERO;
      else begin
        unique case (funct)
          FN_ADD:  alu_op = ALU_ADD;
          FN_SUB:  alu_op = ALU_SUB;
          FN_AND:  alu_op = ALU_AND;
          FN_OR:   alu_op = ALU_OR;
          FN_SLT:  alu_op = ALU_SLT;
          default: alu_op = ALU_ZERO;
        endcase
      end
    end else if (state == S_EXEC_RI) begin
      unique case (opcode)
        OP_ANDI: alu_op = ALU_AND;
        OP_ORI:  alu_op = ALU_OR;
        default: alu_op = ALU_ADD;
      endcase
    end
  end

  assign alu_b = (state == S_EXEC_RR) ? b_q : imm_ext;

  mc_alu #(.W(XLEN)) u_alu (
    .a  (a_q),
    .b  (alu_b),
    .op (alu_op),
    .y  (alu_y)
  );

  assign br_taken = (opcode == OP_BEQ) ? (a_q == b_q) : (a_q != b_q);
  assign rf_we    = (state == S_WRITE);
  assign rf_wsel  = (opcode == OP_RR) ? f_rd : f_rt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q <= RESET_PC;
      ir_q <= '0;
      a_q  <= '0;
      b_q  <= '0;
      r_q  <= '0;
      wb_q <= '0;
    end else begin
      unique case (state)
        S_FETCH: begin
          ir_q <= imem_rdata;
          pc_q <= pc_q + 32'd4;
        end
        S_DECODE: begin
          a_q <= rf_a;
          b_q <= rf_b;
        end
        S_EXEC_RR, S_EXEC_RI, S_ADDR: r_q <= alu_y;
        S_ALU_WB: wb_q <= r_q;
        S_MEM_RD: wb_q <= dmem_rdata;
        S_BRANCH: if (br_taken) pc_q <= pc_q + {imm_sext[29:0], 2'b00};
        S_JUMP:   pc_q <= {pc_q[31:28], ir_q[25:0], 2'b00};
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_q <= '0;
      ret_q <= '0;
    end else begin
      cyc_q <= cyc_q + {{(CNT_W-1){1'b0}}, 1'b1};
      if (retire_w) ret_q <= ret_q + {{(CNT_W-1){1'b0}}, 1'b1};
    end
  end

  assign imem_addr    = pc_q;
  assign pc           = pc_q;
  assign dmem_addr    = r_q;
  assign dmem_wdata   = b_q;
  assign dmem_we      = (state == S_MEM_WR);
  assign retire       = retire_w;
  assign cycle_count  = cyc_q;
  assign retire_count = ret_q;

  p_pc_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((state != S_FETCH) && !retire_w) |=> $stable(pc_q));

  p_fetch_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_FETCH) |=> (pc_q == $past(pc_q) + 32'd4));

  p_store_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dmem_we |=> !dmem_we);

endmodule

// File: tb/test_mc_core.sv
`timescale 1ns/1ps
module test_mc_core;

  typedef struct packed {
    logic [31:0] pc;
    logic [31:0] ins;
    logic [3:0]  cyc;
    logic        st;
    logic [31:0] sa;
    logic [31:0] sd;
  } vec_t;

  function automatic logic [31:0] f_i(input logic [5:0] op, input logic [4:0] rs,
                                      input logic [4:0] rt, input logic [15:0] imm);
    return {op, rs, rt, imm};
  endfunction

  function automatic logic [31:0] f_r(input logic [4:0] rs, input logic [4:0] rt,
                                      input logic [4:0] rd, input logic [5:0] fn);
    return {6'h00, rs, rt, rd, 5'd0, fn};
  endfunction

  function automatic logic [31:0] f_j(input logic [25:0] tgt);
    return {6'h02, tgt};
  endfunction

  localparam int NV = 26;
  localparam vec_t VEC [NV] = '{
    '{32'h00, f_i(6'h08, 5'd0, 5'd1, 16'd5),    4'd5, 1'b0, 32'h0,  32'h0},   // R4 addi
    '{32'h04, f_i(6'h08, 5'd0, 5'd2, 16'hFFFD), 4'd5, 1'b0, 32'h0,  32'h0},   // R4 sign ext
    '{32'h08, f_r(5'd1, 5'd2, 5'd3, 6'h20),     4'd5, 1'b0, 32'h0,  32'h0},   // R3 add
    '{32'h0C, f_r(5'd1, 5'd2, 5'd4, 6'h22),     4'd5, 1'b0, 32'h0,  32'h0},   // R3 sub
    '{32'h10, f_r(5'd2, 5'd1, 5'd5, 6'h2A),     4'd5, 1'b0, 32'h0,  32'h0},   // R3 slt
    '{32'h14, f_i(6'h0D, 5'd0, 5'd6, 16'hF0F0), 4'd5, 1'b0, 32'h0,  32'h0},   // R4 ori
    '{32'h18, f_i(6'h0C, 5'd2, 5'd7, 16'h00FF), 4'd5, 1'b0, 32'h0,  32'h0},   // R4 andi
    '{32'h1C, f_i(6'h08, 5'd0, 5'd0, 16'd7),    4'd5, 1'b0, 32'h0,  32'h0},   // R9 write r0
    '{32'h20, f_i(6'h2B, 5'd0, 5'd3, 16'd0),    4'd4, 1'b1, 32'h00, 32'h2},
    '{32'h24, f_i(6'h2B, 5'd0, 5'd4, 16'd4),    4'd4, 1'b1, 32'h04, 32'h8},
    '{32'h28, f_i(6'h2B, 5'd0, 5'd5, 16'd8),    4'd4, 1'b1, 32'h08, 32'h1},
    '{32'h2C, f_i(6'h2B, 5'd0, 5'd6, 16'd12),   4'd4, 1'b1, 32'h0C, 32'hF0F0},
    '{32'h30, f_i(6'h2B, 5'd0, 5'd7, 16'd16),   4'd4, 1'b1, 32'h10, 32'hFD},
    '{32'h34, f_i(6'h2B, 5'd0, 5'd0, 16'd20),   4'd4, 1'b1, 32'h14, 32'h0},   // R9 reads zero
    '{32'h38, f_r(5'd6, 5'd7, 5'd8, 6'h25),     4'd5, 1'b0, 32'h0,  32'h0},   // R3 or
    '{32'h3C, f_i(6'h23, 5'd0, 5'd10, 16'd4),   4'd5, 1'b0, 32'h0,  32'h0},   // R5 load
    '{32'h40, f_i(6'h2B, 5'd0, 5'd10, 16'd24),  4'd4, 1'b1, 32'h18, 32'h8},
    '{32'h44, f_i(6'h2B, 5'd0, 5'd8, 16'd28),   4'd4, 1'b1, 32'h1C, 32'hF0FD},
    '{32'h48, f_i(6'h04, 5'd1, 5'd2, 16'd5),    4'd3, 1'b0, 32'h0,  32'h0},   // R7 not taken
    '{32'h4C, f_i(6'h05, 5'd1, 5'd2, 16'd2),    4'd3, 1'b0, 32'h0,  32'h0},   // R7 forward
    '{32'h58, f_i(6'h04, 5'd0, 5'd0, 16'hFFFD), 4'd3, 1'b0, 32'h0,  32'h0},   // R7 backward
    '{32'h50, f_j(26'h18),                      4'd3, 1'b0, 32'h0,  32'h0},   // R8 jump
    '{32'h60, f_i(6'h2B, 5'd4, 5'd1, 16'hFFFC), 4'd4, 1'b1, 32'h04, 32'h5},   // R6 neg offset
    '{32'h64, 32'hFC00_0000,                    4'd2, 1'b0, 32'h0,  32'h0},   // R10 unknown
    '{32'h68, f_j(26'h1A),                      4'd3, 1'b0, 32'h0,  32'h0},
    '{32'h68, f_j(26'h1A),                      4'd3, 1'b0, 32'h0,  32'h0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] imem_addr, imem_rdata, dmem_addr, dmem_wdata, dmem_rdata, pc;
  logic        dmem_we, retire;
  logic [31:0] cycle_count, retire_count;
  logic [31:0] imem [64];
  logic [31:0] dmem [64];
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  mc_core i_mc_core (
    .clk(clk), .rst_n(rst_n),
    .imem_addr(imem_addr), .imem_rdata(imem_rdata),
    .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata), .dmem_we(dmem_we),
    .dmem_rdata(dmem_rdata), .pc(pc), .retire(retire),
    .cycle_count(cycle_count), .retire_count(retire_count)
  );

  assign imem_rdata = imem[imem_addr[7:2]];
  assign dmem_rdata = dmem[dmem_addr[7:2]];

  always @(posedge clk) if (dmem_we) dmem[dmem_addr[7:2]] <= dmem_wdata;

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  task automatic reset_checks(input string tag);
    chk({tag, " pc at reset (R1)"}, pc, 32'h0);
    chk({tag, " cycle_count at reset (R1)"}, cycle_count, 32'h0);
    chk({tag, " retire_count at reset (R1)"}, retire_count, 32'h0);
    chk({tag, " retire/we at reset (R1)"}, {30'h0, retire, dmem_we}, 32'h0);
  endtask

  initial begin
    for (int k = 0; k < 64; k++) begin imem[k] = 32'h0; dmem[k] = 32'h0; end
    for (int k = 0; k < NV; k++) imem[VEC[k].pc[7:2]] = VEC[k].ins;
    repeat (3) @(negedge clk);
    reset_checks("initial");
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      int cnt;
      int stores;
      chk($sformatf("instr %0d fetch address (R2 R7 R8 R10)", i), pc, VEC[i].pc);
      cnt = 1;
      stores = 0;
      forever begin
        if (dmem_we) begin
          stores++;
          chk($sformatf("instr %0d store address (R6)", i), dmem_addr, VEC[i].sa);
          chk($sformatf("instr %0d store data (R6 R3 R4 R5 R9)", i), dmem_wdata, VEC[i].sd);
        end
        if (retire || cnt > 12) break;
        @(negedge clk);
        cnt++;
      end
      chk($sformatf("instr %0d cycles to retire (R3 R4 R5 R6 R7 R8 R10 R11)", i),
          cnt, {28'h0, VEC[i].cyc});
      chk($sformatf("instr %0d store strobes (R6 R10)", i), stores, {31'h0, VEC[i].st});
      @(negedge clk);
    end
    chk("total cycle_count (R12)", cycle_count, 32'd106);
    chk("retire_count (R11)", retire_count, NV);
    // asynchronous reset in the middle of execution
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    reset_checks("mid-run");
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog (R11): actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

endmodule